// File: doc/BRIEF.md
# Timestamped Change-of-State Input Logger

This block watches a 48-bit debounced input vector, presented as two 24-bit port words, and samples it once per scan frame. A single-cycle frame strobe marks each scan. Each stored record holds both port words and the value of a 32-bit frame counter. The counter advances once per scan frame, so one count is one frame period (195.3125 µs at a 5120 Hz scan rate). Records wait in an on-chip FIFO until the host drains them.

A mode input picks the logging policy. In continuous mode every frame is recorded. In change-of-state mode a frame is recorded only when at least one of the 48 bits differs from the last recorded frame. Either way, the first frame after reset or after logging is switched on is always recorded. The host reads each record as three words in a fixed order through a read strobe. A strobe on the last word removes the record. While records are waiting and interrupts are enabled, a level interrupt is raised. A record that finds the FIFO full is dropped and sets a sticky overflow flag.

The capture path runs a state machine with three states. CAP_OFF is entered on reset or when logging is disabled. CAP_PRIME means logging is on but no reference frame is held yet. CAP_WATCH compares each frame with the reference. The transitions are:
- CAP_OFF to CAP_PRIME: log_en rises with no frame accepted.
- CAP_OFF to CAP_WATCH, or CAP_PRIME to CAP_WATCH: a frame is accepted into the FIFO.
- Any state to CAP_OFF: log_en falls.

The read path runs a second state machine, RD_P0 to RD_P1 to RD_TS and back to RD_P0. Each step advances on a read strobe while the FIFO holds data.

Top module: `cos_logger`

## Requirements
- R1: After reset, rd_valid, irq and ovf_flag are 0, rd_word is 0, and the frame counter is 0.
- R2: With log_en=1 and mode_cos=0, every frame_tick stores one record, even when the inputs are unchanged.
- R3: With log_en=1 and mode_cos=1, a frame is stored only if its 48 bits differ from the ports of the most recently stored record. Any single-bit 0-to-1 or 1-to-0 change counts.
- R4: The first frame seen while log_en=1, after reset or after log_en was low, is stored regardless of mode or data.
- R5: The timestamp in each record is the number of frame_tick pulses since reset, counted before the current one and modulo 2^32. The count also advances while logging is off.
- R6: A record is read as three words in this order: rd_word=0 gives port 0 in bits 23:0, rd_word=1 gives port 1 in bits 23:0, and rd_word=2 gives the timestamp in bits 31:0. Upper bits are zero. A strobe advances the word, and a strobe on word 2 pops the record. Records leave in the order they were stored.
- R7: rd_strobe while rd_valid=0 has no effect.
- R8: A record that arrives while the FIFO is full, with no pop in the same cycle, is discarded and the stored records are unchanged. ovf_flag is then set and stays set until an ovf_clr pulse.
- R9: The comparison reference for R3 changes only when a record is actually stored. A discarded frame does not become the reference.
- R10: irq is 1 exactly when irq_en=1 and at least one record is waiting.
- R11: frame_tick with log_en=0 stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-cycle scan-frame strobe; inputs are valid in that cycle |
| port0_in | input | 24 | Inputs 0..23 |
| port1_in | input | 24 | Inputs 24..47 |
| log_en | input | 1 | Logging enable |
| mode_cos | input | 1 | 1 = change-of-state logging, 0 = continuous logging |
| irq_en | input | 1 | Interrupt enable |
| rd_strobe | input | 1 | Host read strobe; advances the word or pops the record |
| ovf_clr | input | 1 | Clears the overflow flag |
| rd_valid | output | 1 | At least one record is waiting |
| rd_word | output | 2 | Index of the word currently presented (0, 1, 2) |
| rd_data | output | 32 | Word currently presented |
| irq | output | 1 | Level interrupt |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Continuous logging is driven with a repeated frame followed by a changed frame. This separates recording every frame from recording only on change. Change-of-state logging is driven with the following patterns:
- A frame equal to the old reference right after enable, which shows that the first frame is forced.
- A repeated frame, which must not be stored.
- A single-bit change in one port and then the other, which shows that either port can trigger a record.

A FIFO fill drops a changed frame. The test then offers the last stored frame again, which tells apart a reference that updates on every attempt from one that updates only on a real store. Frames sent with logging off show that the timestamp still advances while nothing is stored.

// File: rtl/cos_pkg.sv
package cos_pkg;

    typedef enum logic [1:0] {
        CAP_OFF   = 2'd0,
        CAP_PRIME = 2'd1,
        CAP_WATCH = 2'd2
    } cap_state_t;

    typedef enum logic [1:0] {
        RD_P0 = 2'd0,
        RD_P1 = 2'd1,
        RD_TS = 2'd2
    } rd_state_t;

endpackage

// File: rtl/cos_tstamp.sv
module cos_tstamp #(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_tick,
    output logic [TS_W-1:0] ts_now
);

    logic [TS_W-1:0] ts_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_q <= '0;
        end else if (frame_tick) begin
            ts_q <= ts_q + 1'b1;
        end
    end

    assign ts_now = ts_q;

endmodule

// File: rtl/cos_detect.sv
module cos_detect
    import cos_pkg::*;
#(
    parameter int PORT_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_tick,
    input  logic              log_en,
    input  logic              mode_cos,
    input  logic [PORT_W-1:0] port0,
    input  logic [PORT_W-1:0] port1,
    input  logic              stored,
    output logic              push
);

    localparam int VEC_W = 2 * PORT_W;

    cap_state_t        state_q;
    cap_state_t        state_d;
    logic [VEC_W-1:0]  ref_q;
    logic [VEC_W-1:0]  now_vec;
    logic              differs;

    assign now_vec = {port1, port0};
    assign differs = |(now_vec ^ ref_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CAP_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        push    = 1'b0;
        unique case (state_q)
            CAP_OFF: begin
                if (log_en) begin
                    push    = frame_tick;
                    state_d = stored ? CAP_WATCH : CAP_PRIME;
                end
            end
            CAP_PRIME: begin
                if (!log_en) begin
                    state_d = CAP_OFF;
                end else begin
                    push = frame_tick;
                    if (stored) state_d = CAP_WATCH;
                end
            end
            CAP_WATCH: begin
                if (!log_en) begin
                    state_d = CAP_OFF;
                end else begin
                    push = frame_tick && (!mode_cos || differs);
                end
            end
            default: state_d = CAP_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= '0;
        end else if (stored) begin
            ref_q <= now_vec;
        end
    end

endmodule

// File: rtl/cos_fifo.sv
module cos_fifo #(
    parameter int DATA_W = 80,
    parameter int DEPTH  = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              not_empty,
    output logic              stored,
    output logic              dropped
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic [CW-1:0]     count;
    logic              full;
    logic              do_pop;

    assign full      = (count == FULL_CNT);
    assign not_empty = (count != '0);
    assign do_pop    = pop && not_empty;
    assign stored    = push && (!full || do_pop);
    assign dropped   = push && !stored;
    assign head      = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (stored) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (stored) begin
                wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            end
            if (stored && !do_pop) begin
                count <= count + 1'b1;
            end else if (do_pop && !stored) begin
                count <= count - 1'b1;
            end
        end
    end

endmodule

// File: rtl/cos_rdport.sv
module cos_rdport
    import cos_pkg::*;
#(
    parameter int PORT_W = 24,
    parameter int TS_W   = 32,
    parameter int WORD_W = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rd_strobe,
    input  logic                         not_empty,
    input  logic [2*PORT_W+TS_W-1:0]     head,
    output logic                         pop,
    output logic [1:0]                   word_idx,
    output logic [WORD_W-1:0]            word_data
);

    rd_state_t state_q;
    rd_state_t state_d;
    logic      step;

    logic [PORT_W-1:0] h_p0;
    logic [PORT_W-1:0] h_p1;
    logic [TS_W-1:0]   h_ts;

    assign h_p0 = head[PORT_W-1:0];
    assign h_p1 = head[2*PORT_W-1:PORT_W];
    assign h_ts = head[2*PORT_W+TS_W-1:2*PORT_W];
    assign step = rd_strobe && not_empty;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RD_P0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        pop       = 1'b0;
        word_data = '0;
        unique case (state_q)
            RD_P0: begin
                word_data = WORD_W'(h_p0);
                if (step) state_d = RD_P1;
            end
            RD_P1: begin
                word_data = WORD_W'(h_p1);
                if (step) state_d = RD_TS;
            end
            RD_TS: begin
                word_data = WORD_W'(h_ts);
                if (step) begin
                    pop     = 1'b1;
                    state_d = RD_P0;
                end
            end
            default: state_d = RD_P0;
        endcase
    end

    assign word_idx = state_q;

endmodule

// File: rtl/cos_logger.sv
module cos_logger #(
    parameter int PORT_W = 24,
    parameter int TS_W   = 32,
    parameter int DEPTH  = 1024
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      frame_tick,
    input  logic [PORT_W-1:0]                         port0_in,
    input  logic [PORT_W-1:0]                         port1_in,
    input  logic                                      log_en,
    input  logic                                      mode_cos,
    input  logic                                      irq_en,
    input  logic                                      rd_strobe,
    input  logic                                      ovf_clr,
    output logic                                      rd_valid,
    output logic [1:0]                                rd_word,
    output logic [((TS_W > PORT_W) ? TS_W : PORT_W)-1:0] rd_data,
    output logic                                      irq,
    output logic                                      ovf_flag
);

    localparam int WORD_W  = (TS_W > PORT_W) ? TS_W : PORT_W;
    localparam int ENTRY_W = 2 * PORT_W + TS_W;

    logic [TS_W-1:0]    ts_now;
    logic               push;
    logic               stored;
    logic               dropped;
    logic               pop;
    logic               not_empty;
    logic [ENTRY_W-1:0] head;
    logic [ENTRY_W-1:0] wdata;
    logic               ovf_q;

    cos_tstamp #(.TS_W(TS_W)) u_ts (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_tick (frame_tick),
        .ts_now     (ts_now)
    );

    cos_detect #(.PORT_W(PORT_W)) u_det (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_tick (frame_tick),
        .log_en     (log_en),
        .mode_cos   (mode_cos),
        .port0      (port0_in),
        .port1      (port1_in),
        .stored     (stored),
        .push       (push)
    );

    assign wdata = {ts_now, port1_in, port0_in};

    cos_fifo #(.DATA_W(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .wdata     (wdata),
        .pop       (pop),
        .head      (head),
        .not_empty (not_empty),
        .stored    (stored),
        .dropped   (dropped)
    );

    cos_rdport #(.PORT_W(PORT_W), .TS_W(TS_W), .WORD_W(WORD_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_strobe (rd_strobe),
        .not_empty (not_empty),
        .head      (head),
        .pop       (pop),
        .word_idx  (rd_word),
        .word_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else if (dropped) begin
            ovf_q <= 1'b1;
        end else if (ovf_clr) begin
            ovf_q <= 1'b0;
        end
    end

    assign ovf_flag = ovf_q;
    assign rd_valid = not_empty;
    assign irq      = irq_en && not_empty;

endmodule

// File: rtl/cos_logger_chk.sv
module cos_logger_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       log_en,
    input logic       irq_en,
    input logic       rd_strobe,
    input logic       ovf_clr,
    input logic       rd_valid,
    input logic [1:0] rd_word,
    input logic       irq,
    input logic       ovf_flag
);

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag && !ovf_clr |=> ovf_flag);

    // R10
    irq_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> !irq);

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    // R7
    idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe && !rd_valid |=> $stable(rd_word));

    // R6
    word_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe && rd_valid && rd_word == 2'd0 |=> rd_word == 2'd1);

    // R6
    word_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_word != 2'd3);

    // R11
    off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !log_en && !rd_strobe |=> $stable(rd_valid));

endmodule

bind cos_logger cos_logger_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .log_en    (log_en),
    .irq_en    (irq_en),
    .rd_strobe (rd_strobe),
    .ovf_clr   (ovf_clr),
    .rd_valid  (rd_valid),
    .rd_word   (rd_word),
    .irq       (irq),
    .ovf_flag  (ovf_flag)
);

// File: tb/sim_cos_logger.sv
module sim_cos_logger;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_tick = 1'b0;
    logic [23:0] port0_in = '0;
    logic [23:0] port1_in = '0;
    logic        log_en = 1'b0;
    logic        mode_cos = 1'b0;
    logic        irq_en = 1'b0;
    logic        rd_strobe = 1'b0;
    logic        ovf_clr = 1'b0;
    logic        rd_valid;
    logic [1:0]  rd_word;
    logic [31:0] rd_data;
    logic        irq;
    logic        ovf_flag;

    int errors = 0;
    int checks = 0;
    int ts_model = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cos_logger #(.PORT_W(24), .TS_W(32), .DEPTH(DEPTH)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_tick (frame_tick),
        .port0_in   (port0_in),
        .port1_in   (port1_in),
        .log_en     (log_en),
        .mode_cos   (mode_cos),
        .irq_en     (irq_en),
        .rd_strobe  (rd_strobe),
        .ovf_clr    (ovf_clr),
        .rd_valid   (rd_valid),
        .rd_word    (rd_word),
        .rd_data    (rd_data),
        .irq        (irq),
        .ovf_flag   (ovf_flag)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic frame(input logic [23:0] a, input logic [23:0] b);
        @(negedge clk);
        port0_in   = a;
        port1_in   = b;
        frame_tick = 1'b1;
        @(negedge clk);
        frame_tick = 1'b0;
        ts_model++;
    endtask

    task automatic strobe();
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    task automatic read_entry(input logic [23:0] a, input logic [23:0] b, input int ts, input string req);
        @(negedge clk);
        check(rd_valid == 1'b1, req, rd_valid, 1);
        check(rd_word == 2'd0 && rd_data == {8'h00, a}, req, rd_data, {8'h00, a});
        strobe();
        check(rd_word == 2'd1 && rd_data == {8'h00, b}, req, rd_data, {8'h00, b});
        strobe();
        check(rd_word == 2'd2 && rd_data == 32'(ts), req, rd_data, ts);
        strobe();
    endtask

    task automatic expect_empty(input string req);
        @(negedge clk);
        check(rd_valid == 1'b0, req, rd_valid, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
        check(irq == 1'b0, "R1 irq", irq, 0);
        check(ovf_flag == 1'b0, "R1 ovf_flag", ovf_flag, 0);
        check(rd_word == 2'd0, "R1 rd_word", rd_word, 0);
    endtask

    task automatic t_continuous();
        log_en = 1'b1; mode_cos = 1'b0;
        frame(24'h00A5A5, 24'h5A0001);   // ts 0, R1 counter starts at 0
        frame(24'h00A5A5, 24'h5A0001);   // ts 1
        frame(24'h123456, 24'hABCDEF);   // ts 2
        read_entry(24'h00A5A5, 24'h5A0001, 0, "R2 R5 R6 entry0");
        read_entry(24'h00A5A5, 24'h5A0001, 1, "R2 R5 R6 entry1 repeated");
        read_entry(24'h123456, 24'hABCDEF, 2, "R2 R6 entry2");
        expect_empty("R2 drained");
    endtask

    task automatic t_cos();
        int t0;
        log_en = 1'b0;
        @(negedge clk);
        mode_cos = 1'b1; log_en = 1'b1;
        t0 = ts_model;
        frame(24'h123456, 24'hABCDEF);   // equals reference, forced by prime
        frame(24'h123456, 24'hABCDEF);   // unchanged: dropped
        frame(24'h123457, 24'hABCDEF);   // port0 bit0 0->1
        frame(24'h123457, 24'hABCDEF);   // unchanged
        frame(24'h123457, 24'h2BCDEF);   // port1 bit23 1->0
        read_entry(24'h123456, 24'hABCDEF, t0,     "R4 forced first frame");
        read_entry(24'h123457, 24'hABCDEF, t0 + 2, "R3 port0 change");
        read_entry(24'h123457, 24'h2BCDEF, t0 + 4, "R3 port1 change");
        expect_empty("R3 no repeats stored");
    endtask

    task automatic t_disabled();
        log_en = 1'b0;
        frame(24'h000001, 24'h000001);
        frame(24'h000002, 24'h000002);
        expect_empty("R11 frames ignored when off");
        @(negedge clk);
        log_en = 1'b1; mode_cos = 1'b1;
        frame(24'h123457, 24'h2BCDEF);
        read_entry(24'h123457, 24'h2BCDEF, ts_model - 1, "R5 R4 counter ran while off");
    endtask

    task automatic t_empty_strobe();
        @(negedge clk);
        strobe();
        strobe();
        check(rd_word == 2'd0, "R7 word unchanged", rd_word, 0);
        check(rd_valid == 1'b0, "R7 still empty", rd_valid, 0);
        frame(24'h0F0F0F, 24'hF0F0F0);
        read_entry(24'h0F0F0F, 24'hF0F0F0, ts_model - 1, "R7 read after idle strobes");
    endtask

    task automatic t_irq();
        irq_en = 1'b0;
        frame(24'h111111, 24'h222222);
        @(negedge clk);
        check(irq == 1'b0, "R10 masked", irq, 0);
        irq_en = 1'b1;
        @(negedge clk);
        check(irq == 1'b1, "R10 asserted", irq, 1);
        read_entry(24'h111111, 24'h222222, ts_model - 1, "R10 entry");
        check(irq == 1'b0, "R10 released when empty", irq, 0);
        irq_en = 1'b0;
    endtask

    task automatic t_overflow();
        int tb;
        mode_cos = 1'b1;
        tb = ts_model;
        frame(24'h000010, 24'h0);
        frame(24'h000020, 24'h0);
        frame(24'h000030, 24'h0);
        frame(24'h000040, 24'h0);
        @(negedge clk);
        check(ovf_flag == 1'b0, "R8 no overflow at full", ovf_flag, 0);
        frame(24'h000050, 24'h0);        // dropped
        @(negedge clk);
        check(ovf_flag == 1'b1, "R8 overflow set", ovf_flag, 1);
        read_entry(24'h000010, 24'h0, tb, "R8 oldest kept");
        frame(24'h000040, 24'h0);        // equals stored reference: not logged
        read_entry(24'h000020, 24'h0, tb + 1, "R8 entry2");
        read_entry(24'h000030, 24'h0, tb + 2, "R8 entry3");
        read_entry(24'h000040, 24'h0, tb + 3, "R8 entry4");
        expect_empty("R9 reference not taken from dropped frame");
        check(ovf_flag == 1'b1, "R8 sticky", ovf_flag, 1);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        check(ovf_flag == 1'b0, "R8 cleared", ovf_flag, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_continuous();
        t_cos();
        t_disabled();
        t_empty_strobe();
        t_irq();
        t_overflow();
        done = 1'b1;
    end

    initial begin
        while (!done && cycles < 20000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
        end
        #1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule